// File: doc/BRIEF.md
# Stepped Normalizing Divider

This block divides a double-width dividend by a single-width divisor under the control of short commands issued by microcode. It holds a quotient, a partial remainder and a divisor internally. A start command loads the upper half of the dividend and the divisor. A step command feeds in the lower half, one bit at a time, and reports how many low-order bits it has not consumed yet. Two read commands return the finished quotient and remainder.

Each arithmetic step lines up the leading one of the divisor with the leading one of the partial remainder. It backs off by one position if the aligned divisor is then too large, and then subtracts. A single step can therefore retire several quotient bits. The microcode repeats the step command with the count it got back until that count is zero. A step issued with a count of zero does nothing, so a loop unrolled past its end costs only a cycle.

Commands use a valid/ready handshake. Bit shift-in runs at one bit per clock while `busy` is high.

Top module: `stepdiv_unit`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1 and `busy`, `rsp_valid`, `rsp_err` and `zero_flag` are 0. The quotient, remainder and divisor are all zero, so both read commands return 0.
- R2: The start command (`cmd_op` = 2'b00) clears the quotient, loads the remainder with `cmd_a`, stores `cmd_b` as the divisor and applies one arithmetic step. Its response arrives one cycle after acceptance, with data 0 and `rsp_err` = 0.
- R3: An arithmetic step whose divisor is larger than the partial remainder leaves the quotient and the remainder unchanged. Example: start(5, 7) gives quotient 0 and remainder 5.
- R4: An arithmetic step shifts the divisor left by (leading-one position of the remainder − leading-one position of the divisor). If the shifted divisor exceeds the remainder, the step uses one position less. It then adds 1 shifted by the final amount to the quotient and subtracts the shifted divisor from the remainder. Examples: start(100, 7) gives quotient 8 and remainder 44; start(100, 3) gives quotient 32 and remainder 4.
- R5: A start command with `cmd_b` = 0, or a step command with a nonzero count while the stored divisor is 0, answers with `rsp_err` = 1 and changes neither the quotient nor the remainder.
- R6: A step command (`cmd_op` = 2'b01) with count `cmd_b` = 0 changes nothing. It answers one cycle later with data 0 and sets `zero_flag`.
- R7: A step command with a nonzero count takes the low dividend half from `cmd_a`. While the count is nonzero and the remainder is below the divisor, each clock shifts bit (count−1) of `cmd_a` into the remainder, shifts the quotient left by one and decrements the count. During this phase `busy` is 1 and `cmd_ready` is 0. One arithmetic step then follows, and the response returns the remaining count. The count never increases while busy.
- R8: `zero_flag` changes only on a response. On a completed step it is 1 exactly when the returned count is 0.
- R9: The quotient read (`cmd_op` = 2'b10) and the remainder read (2'b11) answer one cycle after acceptance with the stored quotient or the stored remainder, and with `rsp_err` = 0.
- R10: When the upper half is below the divisor, the following sequence leaves quotient and remainder equal to the integer quotient and remainder of (upper · 2^k + lower mod 2^k) divided by the divisor: one start command, then step commands repeated with lower half `cmd_a` and the count previously returned (initially k), until the count is 0.
- R11: A step count above the data width W is treated as W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_op | input | 2 | 00 start, 01 step, 10 read quotient, 11 read remainder |
| cmd_a | input | W | Upper dividend half (start) or lower dividend half (step) |
| cmd_b | input | W | Divisor (start) or remaining bit count (step) |
| busy | output | 1 | Bit shift-in in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | W | Read value, remaining count, or 0 |
| rsp_err | output | 1 | Zero-divisor error, valid with `rsp_valid` |
| zero_flag | output | 1 | Last completed step returned a count of zero |

## Verification
On every cycle, the assertions check the following: fixed one-cycle response latency for start, read and zero-count step commands; the error strobe on a zero divisor; the count never increasing during shift-in; and `zero_flag` moving only with a response and matching a step's returned count. The bench's scenarios are the only way to show arithmetic correctness. This covers exact alignment and back-off results, the absence of side effects after an error or a zero-count step, and whole multi-step divisions compared with wide integer division. Those divisions use random operands, dividends smaller than the divisor, maximum-magnitude values, short bit counts and clamped counts.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

    localparam int unsigned DW = 64;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_STEP  = 2'b01,
        OP_RDQ   = 2'b10,
        OP_RDR   = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } state_e;

    typedef struct packed {
        logic       valid;
        logic       err;
        logic [DW-1:0] data;
    } rsp_t;

endpackage

// File: rtl/stepdiv_msb.sv
module stepdiv_msb #(
    parameter int N  = 65,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    // Priority encoder: highest set bit wins, 0 when the vector is empty.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/stepdiv_core.sv
module stepdiv_core #(
    parameter int W  = 64,
    parameter int RW = W + 1,
    parameter int SW = $clog2(RW)
) (
    input  logic [RW-1:0] rem_i,
    input  logic [W-1:0]  dvs_i,
    input  logic [W-1:0]  quo_i,
    output logic [RW-1:0] rem_o,
    output logic [W-1:0]  quo_o
);
    logic [RW-1:0] dx;
    logic [SW-1:0] rem_top, dvs_top, sh, qsh;
    logic [RW-1:0] aligned, sub_val;
    logic          back;
    logic [W-1:0]  qbit;

    assign dx = {1'b0, dvs_i};

    stepdiv_msb #(.N(RW), .IW(SW)) u_msb_rem (.vec(rem_i), .idx(rem_top));
    stepdiv_msb #(.N(RW), .IW(SW)) u_msb_dvs (.vec(dx),    .idx(dvs_top));

    always_comb begin
        sh      = rem_top - dvs_top;
        aligned = dx << sh;
        back    = (aligned > rem_i);
        sub_val = back ? (aligned >> 1) : aligned;
        qsh     = back ? (sh - SW'(1)) : sh;
        qbit    = W'(1) << qsh;
        rem_o   = rem_i;
        quo_o   = quo_i;
        if ((dx != '0) && (dx <= rem_i)) begin
            quo_o = quo_i + qbit;
            rem_o = rem_i - sub_val;
        end
    end
endmodule

// File: rtl/stepdiv_unit.sv
module stepdiv_unit
    import stepdiv_pkg::*;
#(
    parameter int W  = stepdiv_pkg::DW,
    parameter int CW = $clog2(W) + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    output logic         cmd_ready,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] cmd_a,
    input  logic [W-1:0] cmd_b,
    output logic         busy,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data,
    output logic         rsp_err,
    output logic         zero_flag
);
    localparam int RW = W + 1;
    localparam int IW = $clog2(W);

    state_e        st_q;
    logic [W-1:0]  quo_q, dvs_q, low_q;
    logic [RW-1:0] rem_q;
    logic [CW-1:0] cnt_q;
    logic          rv_q, re_q, zf_q;
    logic [W-1:0]  rd_q;

    logic          fire, shift_go;
    op_e           op;
    logic [CW-1:0] cnt_in;
    logic [RW-1:0] core_rem_i, core_rem_o;
    logic [W-1:0]  core_dvs_i, core_quo_i, core_quo_o;

    assign cmd_ready = (st_q == ST_IDLE);
    assign busy      = (st_q == ST_SHIFT);
    assign fire      = cmd_valid && cmd_ready;
    assign op        = op_e'(cmd_op);
    assign cnt_in    = (cmd_b > W'(W)) ? CW'(W) : cmd_b[CW-1:0];
    assign shift_go  = (cnt_q != '0) && (rem_q < {1'b0, dvs_q});

    // Idle: core works on the start operands; shifting: on the registers.
    always_comb begin
        if (st_q == ST_IDLE) begin
            core_rem_i = {1'b0, cmd_a};
            core_quo_i = '0;
            core_dvs_i = cmd_b;
        end else begin
            core_rem_i = rem_q;
            core_quo_i = quo_q;
            core_dvs_i = dvs_q;
        end
    end

    stepdiv_core #(.W(W)) u_core (
        .rem_i (core_rem_i),
        .dvs_i (core_dvs_i),
        .quo_i (core_quo_i),
        .rem_o (core_rem_o),
        .quo_o (core_quo_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            quo_q <= '0;
            dvs_q <= '0;
            low_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
            rv_q  <= 1'b0;
            re_q  <= 1'b0;
            zf_q  <= 1'b0;
            rd_q  <= '0;
        end else begin
            rv_q <= 1'b0;
            re_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (fire) begin
                        case (op)
                            OP_START: begin
                                rv_q <= 1'b1;
                                rd_q <= '0;
                                if (cmd_b == '0) begin
                                    re_q <= 1'b1;
                                end else begin
                                    dvs_q <= cmd_b;
                                    rem_q <= core_rem_o;
                                    quo_q <= core_quo_o;
                                end
                            end
                            OP_STEP: begin
                                if (cnt_in == '0) begin
                                    rv_q <= 1'b1;
                                    rd_q <= '0;
                                    zf_q <= 1'b1;
                                end else if (dvs_q == '0) begin
                                    rv_q <= 1'b1;
                                    re_q <= 1'b1;
                                    rd_q <= '0;
                                end else begin
                                    low_q <= cmd_a;
                                    cnt_q <= cnt_in;
                                    st_q  <= ST_SHIFT;
                                end
                            end
                            OP_RDQ: begin
                                rv_q <= 1'b1;
                                rd_q <= quo_q;
                            end
                            default: begin
                                rv_q <= 1'b1;
                                rd_q <= rem_q[W-1:0];
                            end
                        endcase
                    end
                end
                default: begin
                    if (shift_go) begin
                        rem_q <= {rem_q[RW-2:0], low_q[IW'(cnt_q - CW'(1))]};
                        quo_q <= quo_q << 1;
                        cnt_q <= cnt_q - CW'(1);
                    end else begin
                        rem_q <= core_rem_o;
                        quo_q <= core_quo_o;
                        rv_q  <= 1'b1;
                        rd_q  <= W'(cnt_q);
                        zf_q  <= (cnt_q == '0);
                        st_q  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign rsp_valid = rv_q;
    assign rsp_err   = re_q;
    assign rsp_data  = rd_q;
    assign zero_flag = zf_q;
endmodule

// File: rtl/stepdiv_unit_chk.sv
module stepdiv_unit_chk #(
    parameter int W  = 64,
    parameter int CW = 7
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_valid,
    input logic         cmd_ready,
    input logic [1:0]   cmd_op,
    input logic [W-1:0] cmd_b,
    input logic         busy,
    input logic         rsp_valid,
    input logic [W-1:0] rsp_data,
    input logic         rsp_err,
    input logic         zero_flag,
    input logic [CW-1:0] cnt_q
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    p_start_resp_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 2'b00 && cmd_b != '0) |=> (rsp_valid && !rsp_err && rsp_data == '0));

    p_zero_div_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 2'b00 && cmd_b == '0) |=> (rsp_valid && rsp_err));

    p_err_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);

    p_step_nop_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 2'b01 && cmd_b == '0) |=> (rsp_valid && zero_flag && rsp_data == '0 && !busy));

    p_cnt_down_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cnt_q <= $past(cnt_q)));

    p_zf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $stable(zero_flag));

    p_zf_match_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (rsp_valid && (zero_flag == (rsp_data == '0))));

    p_read_resp_r9: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op[1]) |=> (rsp_valid && !rsp_err));
endmodule

bind stepdiv_unit stepdiv_unit_chk #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_b     (cmd_b),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .zero_flag (zero_flag),
    .cnt_q     (cnt_q)
);

// File: tb/tb_stepdiv_unit.sv
`timescale 1ns/1ps
module tb_stepdiv_unit;
    localparam int W  = 64;
    localparam int CW = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_op = 2'b00;
    logic [W-1:0] cmd_a = '0;
    logic [W-1:0] cmd_b = '0;
    logic         busy, rsp_valid, rsp_err, zero_flag;
    logic [W-1:0] rsp_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stepdiv_unit #(.W(W), .CW(CW)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .zero_flag(zero_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one command; return response data, error, latency and busy/ready one cycle after acceptance.
    task automatic issue(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] data, output logic err, output int lat,
                         output logic busy1, output logic rdy1);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy1 = busy; rdy1 = cmd_ready;
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        data = rsp_data; err = rsp_err;
    endtask

    task automatic read_qr(output logic [W-1:0] q, output logic [W-1:0] r);
        logic e, b1, r1; int l;
        issue(2'b10, '0, '0, q, e, l, b1, r1);
        chk(l == 1 && !e, "R9 quotient read latency/err", W'(l), 1);
        issue(2'b11, '0, '0, r, e, l, b1, r1);
        chk(l == 1 && !e, "R9 remainder read latency/err", W'(l), 1);
    endtask

    task automatic start(input logic [W-1:0] hi, input logic [W-1:0] d, output logic err);
        logic [W-1:0] dat; logic b1, r1; int l;
        issue(2'b00, hi, d, dat, err, l, b1, r1);
        chk(l == 1 && dat == '0, "R2 start response", dat, 0);
    endtask

    task automatic t_reset();
        logic [W-1:0] q, r, dat; logic e, b1, r1; int l;
        chk(cmd_ready && !busy && !rsp_valid && !rsp_err && !zero_flag, "R1 reset outputs",
            W'({cmd_ready, busy, rsp_valid, rsp_err, zero_flag}), W'(5'b10000));
        read_qr(q, r);
        chk(q == '0, "R1 quotient after reset", q, 0);
        chk(r == '0, "R1 remainder after reset", r, 0);
        issue(2'b01, 64'hF, 64'd5, dat, e, l, b1, r1);
        chk(e == 1'b1, "R5 step with zero stored divisor", W'(e), 1);
        chk(zero_flag == 1'b0, "R8 zero_flag untouched by error", W'(zero_flag), 0);
    endtask

    task automatic t_no_sub();
        logic [W-1:0] q, r; logic e;
        start(64'd5, 64'd7, e);
        chk(!e, "R2 start no error", W'(e), 0);
        read_qr(q, r);
        chk(q == 0 && r == 5, "R3 divisor above remainder", {q[31:0], r[31:0]}, {32'd0, 32'd5});
    endtask

    task automatic t_align();
        logic [W-1:0] q, r; logic e;
        start(64'd100, 64'd3, e);
        read_qr(q, r);
        chk(q == 32 && r == 4, "R4 aligned subtract", {q[31:0], r[31:0]}, {32'd32, 32'd4});
        start(64'd100, 64'd7, e);
        read_qr(q, r);
        chk(q == 8 && r == 44, "R4 back-off by one", {q[31:0], r[31:0]}, {32'd8, 32'd44});
    endtask

    task automatic t_zero_div();
        logic [W-1:0] q, r; logic e;
        start(64'd100, 64'd7, e);
        start(64'd50, 64'd0, e);
        chk(e == 1'b1, "R5 zero divisor error", W'(e), 1);
        read_qr(q, r);
        chk(q == 8 && r == 44, "R5 no update on error", {q[31:0], r[31:0]}, {32'd8, 32'd44});
    endtask

    task automatic t_step_zero();
        logic [W-1:0] q, r, dat; logic e, b1, r1; int l;
        issue(2'b01, 64'hFFFF, 64'd0, dat, e, l, b1, r1);
        chk(l == 1 && dat == 0 && zero_flag && !e, "R6 zero-count step response",
            {dat[31:0], 32'(l)}, {32'd0, 32'd1});
        read_qr(q, r);
        chk(q == 8 && r == 44, "R6 zero-count step changes nothing", {q[31:0], r[31:0]}, {32'd8, 32'd44});
    endtask

    task automatic t_step_one();
        logic [W-1:0] q, r, dat; logic e, b1, r1; int l;
        start(64'd3, 64'd5, e);
        issue(2'b01, 64'hA0, 64'd8, dat, e, l, b1, r1);
        chk(b1 && !r1, "R7 busy and not ready while shifting", W'({b1, r1}), W'(2'b10));
        chk(l == 3, "R7 one shift cycle plus one step cycle", W'(l), 3);
        chk(dat == 7 && !e, "R7 remaining count returned", dat, 7);
        chk(zero_flag == 1'b0, "R8 zero_flag clear on nonzero count", W'(zero_flag), 0);
        read_qr(q, r);
        chk(q == 1 && r == 2, "R7 partial result", {q[31:0], r[31:0]}, {32'd1, 32'd2});
    endtask

    task automatic t_full(input logic [W-1:0] hi, input logic [W-1:0] d, input logic [W-1:0] lo,
                          input int k, input string tag);
        logic [W-1:0] q, r, dat, cnt; logic e, b1, r1; int l, it, kk;
        logic [2*W-1:0] dd, eq, er, msk;
        kk  = (k > W) ? W : k;
        msk = (kk == W) ? {{W{1'b0}}, {W{1'b1}}} : ((128'd1 << kk) - 128'd1);
        dd  = ({{W{1'b0}}, hi} << kk) | ({{W{1'b0}}, lo} & msk);
        eq  = dd / {{W{1'b0}}, d};
        er  = dd % {{W{1'b0}}, d};
        start(hi, d, e);
        cnt = W'(k);
        it = 0;
        do begin
            issue(2'b01, lo, cnt, dat, e, l, b1, r1);
            cnt = dat;
            it++;
        end while (cnt != 0 && it < 200);
        chk(zero_flag == 1'b1, {tag, " R8 zero_flag at end"}, W'(zero_flag), 1);
        read_qr(q, r);
        chk(q == eq[W-1:0], {tag, " quotient"}, q, eq[W-1:0]);
        chk(r == er[W-1:0], {tag, " remainder"}, r, er[W-1:0]);
    endtask

    task automatic t_random(input int n);
        logic [W-1:0] d, hi, lo;
        for (int i = 0; i < n; i++) begin
            d  = {$urandom, $urandom};
            if (i % 3 == 1) d = d >> ($urandom % 60);
            if (d == 0) d = 1;
            hi = {$urandom, $urandom} % d;
            lo = {$urandom, $urandom};
            t_full(hi, d, lo, W, "R10 random");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_sub();
        t_align();
        t_zero_div();
        t_step_zero();
        t_step_one();
        t_full(64'd3, 64'd5, 64'hA0, 8, "R10 small");
        t_full(64'd0, 64'd1000, 64'd999, W, "R10 dividend below divisor");
        t_full(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, W, "R10 max");
        t_full(64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, W, "R10 divide by one");
        t_full(64'h1234, 64'h8000_0000_0000_0001, 64'hDEAD_BEEF_0BAD_F00D, 16, "R10 short count");
        t_full(64'h77, 64'h1_0000, 64'h0123_4567_89AB_CDEF, 100, "R11 clamped count");
        t_random(30);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule